// File: doc/BRIEF.md
# Fixed-Timing Read Bridge

This block joins a read-issuing master to a responding slave when both follow fixed-timing read sequences that cannot wait for each other and whose timing does not match. Each side is described by five cycle counts: lead-in control, address, gap, data and trailing control. Both sets of five are parameters, and slot 1 is the cycle in which the master's start strobe is seen while the bridge is idle. From that point every event of a transfer sits in a slot that is fixed before the transfer begins. No handshake takes place at run time.

The bridge starts the slave sequence as early as it can. If the master has a lead-in phase, the trigger comes in the first master address slot. If it has none, the trigger comes right after the master address window. The bridge carries the master's address to the slave and holds it in a register when the two address windows do not share a slot. It takes the slave's read word in the first slave data slot and holds it until the master's data window ends. When the slave data cannot arrive by the start of the master data window, the bridge refuses the parameter set: it raises a constant error and never runs a transfer.

Top module: `nbReadBridge`

## Requirements
- R1: `cfgError` is constant. It is 1 if any address or data length is zero, or if the first slave data slot comes later than the first master data slot. Otherwise it is 0.
- R2: While `cfgError` is 1, `sTrigger`, `sAddrValid` and `mDataValid` stay 0, whatever happens on `mStart`.
- R3: `sTrigger` is high for exactly one cycle, in slot 1+X. X is the master lead-in length when that length is non-zero, and the master address length otherwise. With the default parameters this is slot 2.
- R4: `sAddrValid` is high exactly in the slave address slots. During those slots `sAddr` carries the `mAddr` value from the first master address slot, passed straight through when both fall in the same slot. Outside those slots `sAddr` is 0.
- R5: `mDataValid` is high exactly in the master data slots. During those slots `mData` carries the `sData` value from the first slave data slot, passed straight through when both fall in the same slot. Outside those slots `mData` is 0.
- R6: `mStart` has no effect while a transfer is in progress. A new transfer can start in the slot right after the last slot of the previous one, where the last slot is the later of the two sequence ends.
- R7: Asserting `rstN` low returns the bridge to idle at once, and every output except `cfgError` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mStart | input | 1 | Master transfer start, marks slot 1 |
| mAddr | input | AW | Master read address |
| sTrigger | output | 1 | One-cycle start pulse to the slave |
| sAddr | output | AW | Address presented to the slave |
| sAddrValid | output | 1 | Slave address window active |
| sData | input | DW | Read word from the slave |
| mData | output | DW | Read word returned to the master |
| mDataValid | output | 1 | Master data window active |
| cfgError | output | 1 | Parameter set cannot be bridged |

## Verification
The default tuples are run with several address and data words. The master address is changed right after its window and the slave data right after its first slot, so any output that follows the live inputs instead of the held copies gives the wrong value. A second instance has a lead-in phase and data windows that start together, which exercises the trigger rule for a non-zero lead-in and the same-slot pass-through on both paths. A third, infeasible instance receives start pulses and must stay silent. A start pulse in the middle of a transfer, back-to-back transfers, and a reset in mid-transfer separate correct start acceptance from a re-triggered or stuck sequence.

// File: rtl/nbrPkg.sv
package nbrPkg;

  // Per-slot strobes from the schedule decoder to the datapath
  typedef struct packed {
    logic trig;       // slave start slot
    logic mAddrFirst; // first master address slot
    logic sAddrWin;   // slave address window
    logic sDataFirst; // first slave data slot
    logic mDataWin;   // master data window
  } nbrStrobe_t;

endpackage

// File: rtl/nbrCtrl.sv
module nbrCtrl
  import nbrPkg::*;
#(
  parameter int M1 = 0,
  parameter int M2 = 1,
  parameter int M3 = 4,
  parameter int M4 = 1,
  parameter int M5 = 0,
  parameter int S1 = 0,
  parameter int S2 = 1,
  parameter int S3 = 2,
  parameter int S4 = 3,
  parameter int S5 = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mStart,
  output nbrStrobe_t strobe,
  output logic       cfgError
);

  localparam int MX     = (M1 != 0) ? M1 : M2;
  localparam int TRIG   = 1 + MX;
  localparam int MA_LO  = 1 + M1;
  localparam int MD_LO  = 1 + M1 + M2 + M3;
  localparam int MD_HI  = M1 + M2 + M3 + M4;
  localparam int SA_LO  = TRIG + S1;
  localparam int SA_HI  = SA_LO + S2 - 1;
  localparam int SD_LO  = SA_LO + S2 + S3;
  localparam int M_END  = M1 + M2 + M3 + M4 + M5;
  localparam int S_END  = MX + S1 + S2 + S3 + S4 + S5;
  localparam int LAST   = (M_END > S_END) ? M_END : S_END;
  localparam int CW     = $clog2(LAST + 2);
  localparam bit FEASIBLE = (M2 > 0) && (M4 > 0) && (S2 > 0) && (S4 > 0)
                            && (SD_LO <= MD_LO);
  localparam logic [CW-1:0] LASTV = CW'(LAST);

  logic [CW-1:0] cnt;
  logic [CW-1:0] slotNow;
  logic          busy;

  assign busy = (cnt != '0);

  // Slot 1 is the idle cycle that sees the start strobe
  always_comb begin
    if (busy)                   slotNow = cnt;
    else if (mStart && FEASIBLE) slotNow = CW'(1);
    else                        slotNow = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 cnt <= '0;
    else if (slotNow != '0 && slotNow < LASTV) cnt <= slotNow + CW'(1);
    else                                       cnt <= '0;
  end

  function automatic logic inWin(input int s, input int lo, input int hi);
    return (s != 0) && (s >= lo) && (s <= hi);
  endfunction

  generate
    if (FEASIBLE) begin : g_run
      always_comb begin
        strobe.trig       = (int'(slotNow) == TRIG);
        strobe.mAddrFirst = (int'(slotNow) == MA_LO);
        strobe.sAddrWin   = inWin(int'(slotNow), SA_LO, SA_HI);
        strobe.sDataFirst = (int'(slotNow) == SD_LO);
        strobe.mDataWin   = inWin(int'(slotNow), MD_LO, MD_HI);
      end
    end else begin : g_off
      assign strobe = '0;
    end
  endgenerate

  assign cfgError = !FEASIBLE;

endmodule

// File: rtl/nbrDatapath.sv
module nbrDatapath
  import nbrPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  nbrStrobe_t    strobe,
  input  logic [AW-1:0] mAddr,
  input  logic [DW-1:0] sData,
  output logic          sTrigger,
  output logic [AW-1:0] sAddr,
  output logic          sAddrValid,
  output logic [DW-1:0] mData,
  output logic          mDataValid
);

  logic [AW-1:0] addrHold;
  logic [DW-1:0] dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      dataHold <= '0;
    end else begin
      if (strobe.mAddrFirst) addrHold <= mAddr;
      if (strobe.sDataFirst) dataHold <= sData;
    end
  end

  assign sTrigger   = strobe.trig;
  assign sAddrValid = strobe.sAddrWin;
  assign sAddr      = strobe.sAddrWin
                      ? (strobe.mAddrFirst ? mAddr : addrHold) : '0;
  assign mDataValid = strobe.mDataWin;
  assign mData      = strobe.mDataWin
                      ? (strobe.sDataFirst ? sData : dataHold) : '0;

endmodule

// File: rtl/nbReadBridge.sv
module nbReadBridge
  import nbrPkg::*;
#(
  parameter int M1 = 0,
  parameter int M2 = 1,
  parameter int M3 = 4,
  parameter int M4 = 1,
  parameter int M5 = 0,
  parameter int S1 = 0,
  parameter int S2 = 1,
  parameter int S3 = 2,
  parameter int S4 = 3,
  parameter int S5 = 0,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          mStart,
  input  logic [AW-1:0] mAddr,
  output logic          sTrigger,
  output logic [AW-1:0] sAddr,
  output logic          sAddrValid,
  input  logic [DW-1:0] sData,
  output logic [DW-1:0] mData,
  output logic          mDataValid,
  output logic          cfgError
);

  nbrStrobe_t strobe;

  nbrCtrl #(
    .M1(M1), .M2(M2), .M3(M3), .M4(M4), .M5(M5),
    .S1(S1), .S2(S2), .S3(S3), .S4(S4), .S5(S5)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mStart   (mStart),
    .strobe   (strobe),
    .cfgError (cfgError)
  );

  nbrDatapath #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .mAddr      (mAddr),
    .sData      (sData),
    .sTrigger   (sTrigger),
    .sAddr      (sAddr),
    .sAddrValid (sAddrValid),
    .mData      (mData),
    .mDataValid (mDataValid)
  );

endmodule

// File: rtl/nbReadBridgeChk.sv
module nbReadBridgeChk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          cfgError,
  input logic          sTrigger,
  input logic          sAddrValid,
  input logic [AW-1:0] sAddr,
  input logic          mDataValid,
  input logic [DW-1:0] mData
);

  // R1
  cfg_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgError));

  // R2
  cfg_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!sTrigger && !sAddrValid && !mDataValid));

  // R3
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sTrigger |=> !sTrigger);

  // R4
  addr_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sAddrValid |-> (sAddr == '0));

  // R5
  data_idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mDataValid |-> (mData == '0));

  // R5
  data_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mDataValid && $past(mDataValid)) |-> $stable(mData));

endmodule

bind nbReadBridge nbReadBridgeChk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgError   (cfgError),
  .sTrigger   (sTrigger),
  .sAddrValid (sAddrValid),
  .sAddr      (sAddr),
  .mDataValid (mDataValid),
  .mData      (mData)
);

// File: tb/nbReadBridge_test.sv
module nbReadBridge_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // default instance: master (0,1,4,1,0), slave (0,1,2,3,0)
  logic        mStart = 1'b0;
  logic [15:0] mAddr = '0;
  logic [31:0] sData = '0;
  logic        sTrigger, sAddrValid, mDataValid, cfgError;
  logic [15:0] sAddr;
  logic [31:0] mData;

  nbReadBridge uut (
    .clk(clk), .rstN(rstN), .mStart(mStart), .mAddr(mAddr),
    .sTrigger(sTrigger), .sAddr(sAddr), .sAddrValid(sAddrValid),
    .sData(sData), .mData(mData), .mDataValid(mDataValid), .cfgError(cfgError)
  );

  // infeasible: master (0,1,1,1,0), slave (0,1,3,1,0)
  logic        m2Start = 1'b0;
  logic        s2Trig, s2AddrValid, m2DataValid, cfg2Error;
  logic [15:0] s2Addr;
  logic [31:0] m2Data;

  nbReadBridge #(.M1(0), .M2(1), .M3(1), .M4(1), .M5(0),
                 .S1(0), .S2(1), .S3(3), .S4(1), .S5(0)) uut2 (
    .clk(clk), .rstN(rstN), .mStart(m2Start), .mAddr(16'h1234),
    .sTrigger(s2Trig), .sAddr(s2Addr), .sAddrValid(s2AddrValid),
    .sData(32'hCAFE0000), .mData(m2Data), .mDataValid(m2DataValid),
    .cfgError(cfg2Error)
  );

  // lead-in present, data windows start together: master (2,1,3,1,0), slave (0,1,3,1,1)
  logic        m3Start = 1'b0;
  logic [15:0] m3Addr = '0;
  logic [31:0] s3Data = '0;
  logic        s3Trig, s3AddrValid, m3DataValid, cfg3Error;
  logic [15:0] s3Addr;
  logic [31:0] m3Data;

  nbReadBridge #(.M1(2), .M2(1), .M3(3), .M4(1), .M5(0),
                 .S1(0), .S2(1), .S3(3), .S4(1), .S5(1)) uut3 (
    .clk(clk), .rstN(rstN), .mStart(m3Start), .mAddr(m3Addr),
    .sTrigger(s3Trig), .sAddr(s3Addr), .sAddrValid(s3AddrValid),
    .sData(s3Data), .mData(m3Data), .mDataValid(m3DataValid),
    .cfgError(cfg3Error)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot;
    @(negedge clk);
  endtask

  // {address, data, mid-transfer start pulse}
  localparam logic [48:0] VEC [4] = '{
    {16'hA001, 32'h1111_2222, 1'b0},
    {16'h5A5A, 32'hDEAD_BEEF, 1'b1},
    {16'hFFFF, 32'h0000_0001, 1'b0},
    {16'h0000, 32'hFFFF_FFFF, 1'b1}
  };

  task automatic runMain(input logic [15:0] a, input logic [31:0] d, input logic mid);
    slot; mStart = 1'b1; mAddr = a; #1;
    check("R3 no trigger in slot 1", sTrigger, 0);
    slot; mStart = 1'b0; mAddr = ~a; #1;
    check("R3 trigger in slot 2", sTrigger, 1);
    check("R4 slave address valid slot 2", sAddrValid, 1);
    check("R4 buffered address", sAddr, a);
    slot; mStart = mid; #1;
    check("R4 slave address closed slot 3", sAddrValid, 0);
    check("R4 address zero outside window", sAddr, 0);
    slot; mStart = 1'b0; #1;
    check("R6 no retrigger in slot 4", sTrigger, 0);
    slot; sData = d; #1;
    check("R5 master data not yet valid slot 5", mDataValid, 0);
    slot; sData = ~d; #1;
    check("R5 master data valid slot 6", mDataValid, 1);
    check("R5 held read word", mData, d);
    slot; sData = '0; #1;
    check("R5 master data closed slot 7", mDataValid, 0);
    check("R5 data zero outside window", mData, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) slot;
    #1;
    check("R7 reset trigger low", sTrigger, 0);
    check("R7 reset data valid low", mDataValid, 0);
    rstN = 1'b1;
    slot; #1;
    check("R1 feasible default no error", cfgError, 0);
    check("R1 infeasible set flags error", cfg2Error, 1);
    check("R1 equal data start feasible", cfg3Error, 0);
    check("R7 idle after reset address valid", sAddrValid, 0);

    // table walk, transfers back to back (R6)
    for (int i = 0; i < 4; i++) runMain(VEC[i][48:33], VEC[i][32:1], VEC[i][0]);
    slot; #1;
    check("R6 idle after last transfer", sTrigger, 0);

    // lead-in case: trigger at slot 3, same-slot pass-through both ways
    slot; m3Start = 1'b1; #1;
    check("R3 lead-in no trigger slot 1", s3Trig, 0);
    slot; m3Start = 1'b0; #1;
    check("R3 lead-in no trigger slot 2", s3Trig, 0);
    slot; m3Addr = 16'hBEE5; #1;
    check("R3 lead-in trigger slot 3", s3Trig, 1);
    check("R4 same-slot address pass", s3Addr, 16'hBEE5);
    slot; m3Addr = 16'h0; #1;
    check("R4 lead-in address closed", s3AddrValid, 0);
    slot; slot;
    slot; s3Data = 32'h7654_3210; #1;
    check("R5 same-slot data valid", m3DataValid, 1);
    check("R5 same-slot data pass", m3Data, 32'h7654_3210);
    slot; s3Data = '0; #1;
    check("R5 lead-in data closed", m3DataValid, 0);
    slot;

    // infeasible set never runs
    begin
      logic seen;
      seen = 1'b0;
      slot; m2Start = 1'b1;
      for (int k = 0; k < 12; k++) begin
        #1;
        if (s2Trig || s2AddrValid || m2DataValid) seen = 1'b1;
        slot; m2Start = (k % 3 == 0);
      end
      m2Start = 1'b0;
      check("R2 infeasible stays silent", seen, 0);
    end

    // reset in mid-transfer
    slot; mStart = 1'b1; mAddr = 16'h4321;
    slot; mStart = 1'b0; #1;
    check("R3 trigger before reset", sTrigger, 1);
    rstN = 1'b0; #1;
    check("R7 async reset clears address valid", sAddrValid, 0);
    slot; slot; rstN = 1'b1;
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
        slot; #1;
        if (sTrigger || mDataValid || sAddrValid) seen = 1'b1;
      end
      check("R7 no leftover activity after reset", seen, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule